// File: doc/BRIEF.md
# Scanline Sprite Line-Buffer Renderer

This block paints one video line of sprites into a line buffer. A start-of-line strobe begins a walk through a table of sprite descriptors. Each descriptor whose vertical span covers the current line triggers a fetch of one 16-pixel row from a byte-per-pixel definition memory, and every pixel whose colour index is not zero is written to the line buffer at the sprite's horizontal position. The row can be written in reverse order.

A sprite is one or more 16x16 blocks stacked vertically. Rows below the first block come from the blocks that follow the sprite's base block in definition memory. A fixed budget limits how many sprites can be drawn on one line. Any qualifying sprite found after the budget is used up is skipped on that line only.

Both memory read ports have one cycle of latency. The line buffer is a plain write port, and the surrounding video logic clears it between lines.

Top module: `sprite_line_renderer`

## Requirements
- R1: While reset is held and after it is released with no strobe, `busy` is low and `lb_we` is low.
- R2: After a `line_start` pulse, descriptors 0 to NUM_DESC-1 are read once each in ascending index order. `busy` is high from the cycle after the strobe and stays high for exactly 2·NUM_DESC + 17·D cycles, where D is the number of sprites drawn on that line. It then stays low.
- R3: A fetched pixel byte equal to 0 produces no line-buffer write. Every other byte of a drawn row produces exactly one write.
- R4: A descriptor is a 32-bit word with these fields: bits [8:0] give X, bits [17:9] give Y, bits [26:18] give the base block number, bits [30:27] give the height code H, and bit 31 is the mirror flag. With row = (line − Y) mod 512, the sprite is selected when row < 16·H.
- R5: A height code of 0 selects 15 blocks, so the sprite covers rows 0 to 239 and not row 240.
- R6: The byte for column c (0 to 15) is read at address ((block + row/16) mod 512)·256 + (row mod 16)·16 + c. When the mirror flag is 0, it is written at line-buffer address (X + c) mod 512.
- R7: When the mirror flag is 1, the byte for column c is written at (X + 15 − c) mod 512.
- R8: No more than MAX_PER_LINE sprites are drawn on one line. A selected sprite that comes after the budget is exhausted is skipped on that line and can still be drawn on later lines.
- R9: Sprites are drawn in descriptor index order. Where two sprites write the same line-buffer position, the higher index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse that starts the walk for `line_num` |
| line_num | input | 9 | Line number, sampled on `line_start` |
| desc_addr | output | $clog2(NUM_DESC) | Descriptor table read address |
| desc_rdata | input | 32 | Descriptor word, valid one cycle after its address |
| def_addr | output | 17 | Definition memory byte address |
| def_rdata | input | 8 | Pixel byte, valid one cycle after its address |
| lb_we | output | 1 | Line-buffer write enable |
| lb_addr | output | 9 | Line-buffer write address |
| lb_wdata | output | 8 | Line-buffer write data (colour index) |
| busy | output | 1 | High while a line walk is in progress |

## Verification
The bench sweeps all 512 line numbers over a small table of 12 descriptors with a budget of 4. The sprites are placed so that lines see overlaps, a row that wraps past X = 511, a vertical span that wraps past line 511, a base block number that wraps past 511, and more qualifying sprites than the budget allows. On each line the whole line buffer is compared with an arithmetic model. A wrong block offset for tall sprites would corrupt rows 16 and beyond. A mirror error would shift pixels within the sprite. A budget counter that never resets would lose sprites on later lines. Reversed walk order would let the lower index win an overlap. Targeted checks cover the 240th and 241st rows of a height-0 sprite, the line where a skipped sprite comes back, and an overlapped pixel. The busy length and the write count on each line expose extra or missing fetches, and also writes of transparent pixels.

// File: rtl/sprite_lb_pkg.sv
package sprite_lb_pkg;

    localparam int COORD_W   = 9;
    localparam int DEFN_W    = 9;
    localparam int HCODE_W   = 4;
    localparam int PIX_W     = 8;
    localparam int SPR_W     = 16;
    localparam int COL_W     = $clog2(SPR_W);
    localparam int ROWB_W    = DEFN_W + COL_W;
    localparam int DADDR_W   = ROWB_W + COL_W;
    localparam int SPAN_W    = HCODE_W + COL_W + 1;
    localparam int MAX_BLKS  = (1 << HCODE_W) - 1;

    // Descriptor word layout, high bit first
    typedef struct packed {
        logic               mirror;
        logic [HCODE_W-1:0] hcode;
        logic [DEFN_W-1:0]  blk;
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] x;
    } spr_desc_t;

    localparam int DESC_W = $bits(spr_desc_t);

    // Work order handed from the walker to the row fetcher
    typedef struct packed {
        logic [ROWB_W-1:0]  row_base;
        logic [COORD_W-1:0] x;
        logic               mirror;
    } fetch_job_t;

    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_READ,
        WALK_TEST,
        WALK_DRAW
    } walk_state_e;

    // Number of lines covered by a height code; code 0 gives the tallest sprite
    function automatic logic [SPAN_W-1:0] span_lines(input logic [HCODE_W-1:0] hc);
        logic [HCODE_W-1:0] blocks;
        blocks = (hc == '0) ? HCODE_W'(MAX_BLKS) : hc;
        return {1'b0, blocks, {COL_W{1'b0}}};
    endfunction

    function automatic logic [COORD_W-1:0] row_of(input spr_desc_t d,
                                                  input logic [COORD_W-1:0] line);
        return line - d.y;
    endfunction

    function automatic logic covers_line(input spr_desc_t d,
                                         input logic [COORD_W-1:0] line);
        return SPAN_W'(row_of(d, line)) < span_lines(d.hcode);
    endfunction

    // Block number advanced by the row's block offset, then row-in-block
    function automatic logic [ROWB_W-1:0] row_base_of(input spr_desc_t d,
                                                      input logic [COORD_W-1:0] line);
        logic [COORD_W-1:0] row;
        logic [DEFN_W-1:0]  blk;
        row = row_of(d, line);
        blk = d.blk + DEFN_W'(row[2*COL_W-1:COL_W]);
        return {blk, row[COL_W-1:0]};
    endfunction

endpackage

// File: rtl/sprite_desc_walk.sv
module sprite_desc_walk
    import sprite_lb_pkg::*;
#(
    parameter int NUM_DESC     = 127,
    parameter int MAX_PER_LINE = 55,
    localparam int IDX_W       = $clog2(NUM_DESC),
    localparam int CNT_W       = $clog2(MAX_PER_LINE + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_start,
    input  logic [COORD_W-1:0] line_num,
    output logic [IDX_W-1:0]   desc_addr,
    input  logic [DESC_W-1:0]  desc_rdata,
    output logic               job_valid,
    output fetch_job_t         job,
    input  logic               job_done,
    output logic               busy
);

    walk_state_e        state;
    logic [IDX_W-1:0]   idx;
    logic [CNT_W-1:0]   drawn;
    logic [COORD_W-1:0] line_q;
    spr_desc_t          desc;
    logic               budget_left;
    logic               take;
    logic               advance;
    logic               last_idx;

    always_comb begin
        desc        = spr_desc_t'(desc_rdata);
        budget_left = drawn < CNT_W'(MAX_PER_LINE);
        take        = (state == WALK_TEST) && covers_line(desc, line_q) && budget_left;
        advance     = ((state == WALK_TEST) && !take) ||
                      ((state == WALK_DRAW) && job_done);
        last_idx    = idx == IDX_W'(NUM_DESC - 1);
        job_valid   = take;
        job.row_base = row_base_of(desc, line_q);
        job.x        = desc.x;
        job.mirror   = desc.mirror;
        desc_addr   = idx;
        busy        = state != WALK_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WALK_IDLE;
            idx    <= '0;
            drawn  <= '0;
            line_q <= '0;
        end else if (line_start) begin
            state  <= WALK_READ;
            idx    <= '0;
            drawn  <= '0;
            line_q <= line_num;
        end else begin
            if (state == WALK_READ) begin
                state <= WALK_TEST;
            end
            if (take) begin
                state <= WALK_DRAW;
                drawn <= drawn + 1'b1;
            end
            if (advance) begin
                if (last_idx) begin
                    state <= WALK_IDLE;
                end else begin
                    state <= WALK_READ;
                    idx   <= idx + 1'b1;
                end
            end
        end
    end

    AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (rst)
        drawn <= CNT_W'(MAX_PER_LINE)); // R8
    AST_FULL_NO_JOB: assert property (@(posedge clk) disable iff (rst)
        (drawn == CNT_W'(MAX_PER_LINE)) |-> !job_valid); // R8
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        idx <= IDX_W'(NUM_DESC - 1)); // R2
    AST_DRAW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == WALK_DRAW && !job_done && !line_start) |=> (state == WALK_DRAW && $stable(idx))); // R9

endmodule

// File: rtl/sprite_row_fetch.sv
module sprite_row_fetch
    import sprite_lb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               abort,
    input  logic               job_valid,
    input  fetch_job_t         job,
    output logic [DADDR_W-1:0] def_addr,
    input  logic [PIX_W-1:0]   def_rdata,
    output logic               lb_we,
    output logic [COORD_W-1:0] lb_addr,
    output logic [PIX_W-1:0]   lb_wdata,
    output logic               done
);

    fetch_job_t       job_q;
    logic             active;
    logic [COL_W-1:0] col;
    logic             rvalid;
    logic [COL_W-1:0] rcol;
    logic [COL_W-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            active <= 1'b0;
            col    <= '0;
            rvalid <= 1'b0;
            rcol   <= '0;
            job_q  <= '0;
        end else begin
            rvalid <= active;
            rcol   <= col;
            if (job_valid) begin
                active <= 1'b1;
                col    <= '0;
                job_q  <= job;
            end else if (active) begin
                col <= col + 1'b1;
                if (col == '1) begin
                    active <= 1'b0;
                end
            end
        end
    end

    // Mirrored rows land at X + 15 - c, which is the bitwise complement of c
    always_comb begin
        def_addr = {job_q.row_base, col};
        pos      = job_q.mirror ? ~rcol : rcol;
        lb_addr  = job_q.x + COORD_W'(pos);
        lb_wdata = def_rdata;
        lb_we    = rvalid && (def_rdata != '0);
        done     = rvalid && (rcol == '1);
    end

    AST_JOB_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        job_valid |-> (!active && !rvalid)); // R2
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(active) && !active)); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && !$past(job_valid) && !$past(abort)) |-> (def_addr == $past(def_addr) + 1'b1)); // R6

endmodule

// File: rtl/sprite_line_renderer.sv
module sprite_line_renderer
    import sprite_lb_pkg::*;
#(
    parameter int NUM_DESC     = 127,
    parameter int MAX_PER_LINE = 55,
    localparam int IDX_W       = $clog2(NUM_DESC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_start,
    input  logic [COORD_W-1:0] line_num,
    output logic [IDX_W-1:0]   desc_addr,
    input  logic [DESC_W-1:0]  desc_rdata,
    output logic [DADDR_W-1:0] def_addr,
    input  logic [PIX_W-1:0]   def_rdata,
    output logic               lb_we,
    output logic [COORD_W-1:0] lb_addr,
    output logic [PIX_W-1:0]   lb_wdata,
    output logic               busy
);

    logic       job_valid;
    fetch_job_t job;
    logic       job_done;

    sprite_desc_walk #(
        .NUM_DESC     (NUM_DESC),
        .MAX_PER_LINE (MAX_PER_LINE)
    ) u_walk (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .line_num   (line_num),
        .desc_addr  (desc_addr),
        .desc_rdata (desc_rdata),
        .job_valid  (job_valid),
        .job        (job),
        .job_done   (job_done),
        .busy       (busy)
    );

    sprite_row_fetch u_fetch (
        .clk       (clk),
        .rst       (rst),
        .abort     (line_start),
        .job_valid (job_valid),
        .job       (job),
        .def_addr  (def_addr),
        .def_rdata (def_rdata),
        .lb_we     (lb_we),
        .lb_addr   (lb_addr),
        .lb_wdata  (lb_wdata),
        .done      (job_done)
    );

    AST_START_WALK: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (busy && desc_addr == '0)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !lb_we); // R1

endmodule

// File: tb/sprite_line_renderer_test.sv
`timescale 1ns/1ps
module sprite_line_renderer_test;

    localparam int N    = 12;
    localparam int MAXL = 4;
    localparam int AW   = $clog2(N);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_start = 1'b0;
    logic [8:0]  line_num = '0;
    logic [AW-1:0] desc_addr;
    logic [31:0] desc_rdata = '0;
    logic [16:0] def_addr;
    logic [7:0]  def_rdata = '0;
    logic        lb_we;
    logic [8:0]  lb_addr;
    logic [7:0]  lb_wdata;
    logic        busy;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [31:0] desc_mem [N];
    logic [7:0]  lb_img  [512];
    logic [7:0]  exp_img [512];
    int          wr_count;
    int          exp_wr;
    int          exp_drawn;

    always #4 clk = ~clk;

    sprite_line_renderer #(.NUM_DESC(N), .MAX_PER_LINE(MAXL)) uut (
        .clk(clk), .rst(rst), .line_start(line_start), .line_num(line_num),
        .desc_addr(desc_addr), .desc_rdata(desc_rdata),
        .def_addr(def_addr), .def_rdata(def_rdata),
        .lb_we(lb_we), .lb_addr(lb_addr), .lb_wdata(lb_wdata), .busy(busy));

    function automatic logic [7:0] defval(input int a);
        if ((a & 15) == 6) return 8'd0;
        return 8'((a % 251) + 1);
    endfunction

    function automatic logic [31:0] mk(input int x, input int y, input int blk,
                                       input int h, input int m);
        return {m[0], h[3:0], blk[8:0], y[8:0], x[8:0]};
    endfunction

    always @(posedge clk) begin
        desc_rdata <= (int'(desc_addr) < N) ? desc_mem[desc_addr] : 32'd0;
        def_rdata  <= defval(int'(def_addr));
        if (lb_we) begin
            lb_img[lb_addr] <= lb_wdata;
            wr_count <= wr_count + 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_line(input int line);
        exp_wr = 0;
        exp_drawn = 0;
        for (int p = 0; p < 512; p++) exp_img[p] = 8'd0;
        for (int i = 0; i < N; i++) begin
            int x, y, blk, h, m, row;
            x = int'(desc_mem[i][8:0]);
            y = int'(desc_mem[i][17:9]);
            blk = int'(desc_mem[i][26:18]);
            h = int'(desc_mem[i][30:27]);
            m = int'(desc_mem[i][31]);
            if (h == 0) h = 15;
            row = (line - y) & 511;
            if (row < h * 16 && exp_drawn < MAXL) begin
                exp_drawn++;
                for (int c = 0; c < 16; c++) begin
                    int a, pos;
                    logic [7:0] v;
                    a = (((blk + (row >> 4)) & 511) << 8) | ((row & 15) << 4) | c;
                    v = defval(a);
                    pos = (m != 0) ? 15 - c : c;
                    if (v != 0) begin
                        exp_img[(x + pos) & 511] = v;
                        exp_wr++;
                    end
                end
            end
        end
    endtask

    task automatic run_line(input int line);
        int bcnt;
        @(negedge clk);
        for (int p = 0; p < 512; p++) lb_img[p] = 8'd0;
        wr_count = 0;
        line_num = 9'(line);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        bcnt = 0;
        while (busy) begin
            bcnt++;
            @(negedge clk);
        end
        model_line(line);
        check($sformatf("R2 busy length line %0d", line), bcnt, 2 * N + 17 * exp_drawn);
        check($sformatf("R3 write count line %0d", line), wr_count, exp_wr);
        for (int p = 0; p < 512; p++) begin
            vectors++;
            if (lb_img[p] != exp_img[p]) begin
                miscompares++;
                $display("FAIL R4 R6 R7 R9 line %0d pixel %0d: actual %0d expected %0d",
                         line, p, lb_img[p], exp_img[p]);
            end
        end
    endtask

    initial begin
        desc_mem[0]  = mk(10, 20, 3, 1, 0);
        desc_mem[1]  = mk(18, 24, 7, 2, 1);
        desc_mem[2]  = mk(505, 30, 100, 0, 0);
        desc_mem[3]  = mk(200, 0, 510, 15, 1);
        desc_mem[4]  = mk(120, 100, 24, 1, 0);
        for (int i = 5; i < 10; i++) desc_mem[i] = mk(40 + i * 20, 100, 20 + i, 3, i & 1);
        desc_mem[10] = mk(300, 500, 50, 2, 0);
        desc_mem[11] = mk(100, 300, 9, 1, 1);

        repeat (3) @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 lb_we in reset", int'(lb_we), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 lb_we after reset", int'(lb_we), 0);

        for (int line = 0; line < 512; line++) begin
            run_line(line);
            if (line == 269)
                check("R5 height code 0 row 239", int'(lb_img[505]),
                      int'(defval(((100 + 14) << 8) | (15 << 4))));
            if (line == 270)
                check("R5 height code 0 row 240 absent", int'(lb_img[505]), 0);
            if (line == 115)
                check("R8 sprite 6 skipped over budget", int'(lb_img[161]), 0);
            if (line == 116)
                check("R8 sprite 6 back on later line", int'(lb_img[161]),
                      int'(defval((27 << 8) | 1)));
            if (line == 25)
                check("R9 later mirrored sprite wins overlap", int'(lb_img[20]),
                      int'(defval((7 << 8) | (1 << 4) | 13)));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL R2 watchdog: actual hung expected walk completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule